// File: doc/BRIEF.md
# Scratchpad Bank Transfer Controller

This block moves bytes between a processor's 32-entry register file and a set of scratchpad register banks. A command gives an operation, an 8-bit device number, a start register, a start byte lane within that register and a byte count. Three local banks and one peer bank each have their own device number. Register N, lane L of the register file is always paired with register N, lane L of the chosen bank. The controller moves one byte per clock. After each byte it steps the lane, and when the lane wraps from 3 to 0 it moves on to the next register.

There are three operations: read-in (bank to registers), write-out (registers to bank) and swap. A swap takes the old byte from both sides in the same step and writes each into the other. Two reserved device numbers do not touch any bank: 254 fills the addressed register bytes with 0xFF and 255 fills them with 0x00. Device 0 is not handled here. A valid read-in or write-out to device 0 is only signalled onward to the multiply-accumulate unit. Any other combination of device and operation is rejected with a one-cycle error pulse.

Top module: `scratch_xfer`

## Requirements
- R1: After reset, busy, err and macFwd are low, and every register-file and bank byte enable and both bank enables are low.
- R2: Read-in from a bank (op code 0): for each byte, rfAddr and bankAddr are both the current register. rfByteEn is one-hot on the current lane, with lane 0 as bit 0. rfWrData holds that lane's byte of bankRdData, replicated in every lane. bankByteEn stays zero.
- R3: Write-out to a bank (op code 1): for each byte, bankByteEn is one-hot on the current lane. bankWrData holds that lane's byte of rfRdData, replicated in every lane. rfByteEn stays zero.
- R4: The transfer starts at the given register and lane. The lane steps by one per byte, and after lane 3 it returns to lane 0 with the register index one higher.
- R5: Swap (op code 2): in each step both byte enables are set on the current lane. The register file receives the bank's old byte and the bank receives the register file's old byte. Both are read before either is written.
- R6: Read-in from device 254 writes 0xFF, and from device 255 writes 0x00, into each addressed register byte. Both bank enables stay low.
- R7: Devices 10, 11 and 12 assert bankEn with bankSel 0, 1 and 2. Device 14 asserts peerEn and not bankEn. The enable is held for every byte of the transfer.
- R8: These commands cause a one-cycle err pulse in the cycle after acceptance, with no busy and no writes: an unknown device number, op code 3, write-out or swap to device 254 or 255, and swap to device 0.
- R9: Read-in or write-out to device 0 gives a one-cycle macFwd pulse in the cycle after acceptance, with no busy and no writes.
- R10: For a bank or fill device, the command is rejected as in R8 if the length is 0 or above 124, or if start register × 4 + start lane + length exceeds 128. A transfer ending exactly at byte 128 is accepted.
- R11: A command presented while busy is high is ignored. It produces no err, no macFwd and no extra transfer steps.
- R12: busy rises in the cycle after a transfer command is accepted and stays high for exactly length cycles, one byte per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, sampled when idle |
| cmdOp | input | 2 | 0 read-in, 1 write-out, 2 swap, 3 reserved |
| cmdDev | input | 8 | Device number |
| cmdReg | input | 5 | Start register |
| cmdLane | input | 2 | Start byte lane |
| cmdLen | input | 7 | Byte count |
| busy | output | 1 | High for each byte step |
| err | output | 1 | Rejected-command pulse |
| macFwd | output | 1 | Device 0 forward pulse |
| rfAddr | output | 5 | Register file index |
| rfByteEn | output | 4 | Register file byte write enables |
| rfWrData | output | 32 | Register file write data |
| rfRdData | input | 32 | Register file read data (combinational) |
| bankAddr | output | 5 | Bank register index |
| bankSel | output | 2 | Local bank select |
| bankEn | output | 1 | Local bank access enable |
| peerEn | output | 1 | Peer bank access enable |
| bankByteEn | output | 4 | Bank byte write enables |
| bankWrData | output | 32 | Bank write data |
| bankRdData | input | 32 | Bank read data (combinational) |

## Verification
A command is accepted on the rising edge that samples cmdValid. Its first byte step, or its err or macFwd pulse, appears in the following cycle. The k-th byte of a transfer is due k−1 cycles after that. For each command, the driver queues one expected item per cycle in which output activity is due. On every falling edge where busy, err or macFwd is high, the monitor pops one item and compares the addresses, enables and lane data. A command whose items are still queued a few cycles after its last expected step is reported as missing output. Any activity found with an empty queue is reported as unexpected. After all commands, the bench's memory models are compared with reference copies that were updated only from the requirements.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int NUM_REGS    = 32;
  localparam int LANES       = 4;
  localparam int REG_W       = $clog2(NUM_REGS);
  localparam int LANE_W      = $clog2(LANES);
  localparam int WORD_W      = 8 * LANES;
  localparam int TOTAL_BYTES = NUM_REGS * LANES;
  localparam int START_W     = REG_W + LANE_W;

  typedef enum logic [1:0] {
    OP_READIN  = 2'd0,
    OP_WRITEOUT = 2'd1,
    OP_SWAP    = 2'd2,
    OP_RSVD    = 2'd3
  } xferOp_e;

  typedef struct packed {
    logic              active;
    logic              wrRf;
    logic              wrBank;
    logic              useBank;
    logic              usePeer;
    logic [1:0]        bankSel;
    logic              fill;
    logic [7:0]        fillByte;
    logic [REG_W-1:0]  regIdx;
    logic [LANE_W-1:0] lane;
  } strobe_t;
endpackage

// File: rtl/spx_ctrl.sv
module spx_ctrl
  import spx_pkg::*;
#(
  parameter int DEV_W     = 8,
  parameter int MAX_LEN   = 124,
  parameter int DEV_MAC   = 0,
  parameter int DEV_BANK0 = 10,
  parameter int DEV_BANK1 = 11,
  parameter int DEV_BANK2 = 12,
  parameter int DEV_PEER  = 14,
  parameter int DEV_ONES  = 254,
  parameter int DEV_ZEROS = 255,
  localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [DEV_W-1:0]  cmdDev,
  input  logic [REG_W-1:0]  cmdReg,
  input  logic [LANE_W-1:0] cmdLane,
  input  logic [LEN_W-1:0]  cmdLen,
  output logic              busy,
  output logic              err,
  output logic              macFwd,
  output strobe_t           str
);
  localparam int SUM_W = ((START_W > LEN_W) ? START_W : LEN_W) + 1;

  logic              busyQ, errQ, macQ;
  logic [START_W-1:0] ptrQ;
  logic [LEN_W-1:0]  remainQ;
  xferOp_e           opQ;
  logic              peerQ, fillQ;
  logic [1:0]        selQ;
  logic [7:0]        fillByteQ;

  logic isLocal, isPeer, isOnes, isZeros, isMac;
  logic [1:0] selD;
  logic rangeOk, opKnown, startOk, macOk;
  logic [SUM_W-1:0] endByte;

  always_comb begin
    isLocal = 1'b1;
    selD    = 2'd0;
    if (cmdDev == DEV_W'(DEV_BANK0))      selD = 2'd0;
    else if (cmdDev == DEV_W'(DEV_BANK1)) selD = 2'd1;
    else if (cmdDev == DEV_W'(DEV_BANK2)) selD = 2'd2;
    else isLocal = 1'b0;
    isPeer  = (cmdDev == DEV_W'(DEV_PEER));
    isOnes  = (cmdDev == DEV_W'(DEV_ONES));
    isZeros = (cmdDev == DEV_W'(DEV_ZEROS));
    isMac   = (cmdDev == DEV_W'(DEV_MAC));
    endByte = SUM_W'({cmdReg, cmdLane}) + SUM_W'(cmdLen);
    rangeOk = (cmdLen != '0) && (cmdLen <= LEN_W'(MAX_LEN))
              && (endByte <= SUM_W'(TOTAL_BYTES));
    opKnown = (cmdOp != OP_RSVD);
    macOk   = isMac && (cmdOp == OP_READIN || cmdOp == OP_WRITEOUT);
    startOk = rangeOk && (((isLocal || isPeer) && opKnown)
              || ((isOnes || isZeros) && cmdOp == OP_READIN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      errQ      <= 1'b0;
      macQ      <= 1'b0;
      ptrQ      <= '0;
      remainQ   <= '0;
      opQ       <= OP_READIN;
      peerQ     <= 1'b0;
      fillQ     <= 1'b0;
      selQ      <= 2'd0;
      fillByteQ <= 8'h00;
    end else begin
      errQ <= 1'b0;
      macQ <= 1'b0;
      if (busyQ) begin
        ptrQ    <= ptrQ + 1'b1;
        remainQ <= remainQ - 1'b1;
        if (remainQ == LEN_W'(1)) busyQ <= 1'b0;
      end else if (cmdValid) begin
        if (macOk) begin
          macQ <= 1'b1;
        end else if (startOk) begin
          busyQ     <= 1'b1;
          ptrQ      <= {cmdReg, cmdLane};
          remainQ   <= cmdLen;
          opQ       <= xferOp_e'(cmdOp);
          peerQ     <= isPeer;
          fillQ     <= isOnes || isZeros;
          selQ      <= selD;
          fillByteQ <= isOnes ? 8'hFF : 8'h00;
        end else begin
          errQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    str.active   = busyQ;
    str.wrRf     = busyQ && (opQ == OP_READIN || opQ == OP_SWAP);
    str.wrBank   = busyQ && (opQ == OP_WRITEOUT || opQ == OP_SWAP);
    str.useBank  = busyQ && !fillQ;
    str.usePeer  = peerQ;
    str.bankSel  = selQ;
    str.fill     = fillQ;
    str.fillByte = fillByteQ;
    str.regIdx   = ptrQ[START_W-1:LANE_W];
    str.lane     = ptrQ[LANE_W-1:0];
  end

  assign busy   = busyQ;
  assign err    = errQ;
  assign macFwd = macQ;

  // R8: a rejection never overlaps a transfer
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> !busyQ);
  // R9: a forward pulse never overlaps a transfer
  a_r9_mac_idle: assert property (@(posedge clk) disable iff (!rstN)
    macQ |-> !busyQ);
  // R11: a command seen while busy raises no pulse
  a_r11_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cmdValid) |=> (!errQ && !macQ));
  // R4: byte position steps by exactly one between consecutive steps
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> ({str.regIdx, str.lane} == $past({str.regIdx, str.lane}) + 1'b1));
endmodule

// File: rtl/spx_dp.sv
module spx_dp
  import spx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           str,
  output logic [REG_W-1:0]  rfAddr,
  output logic [LANES-1:0]  rfByteEn,
  output logic [WORD_W-1:0] rfWrData,
  input  logic [WORD_W-1:0] rfRdData,
  output logic [REG_W-1:0]  bankAddr,
  output logic [1:0]        bankSel,
  output logic              bankEn,
  output logic              peerEn,
  output logic [LANES-1:0]  bankByteEn,
  output logic [WORD_W-1:0] bankWrData,
  input  logic [WORD_W-1:0] bankRdData
);
  logic [LANES-1:0] laneOh;
  logic [7:0] rfByte, bankByte, toRf;

  always_comb begin
    laneOh   = '0;
    laneOh[str.lane] = 1'b1;
    rfByte   = rfRdData[8*str.lane +: 8];
    bankByte = bankRdData[8*str.lane +: 8];
    toRf     = str.fill ? str.fillByte : bankByte;
  end

  assign rfAddr     = str.regIdx;
  assign bankAddr   = str.regIdx;
  assign bankSel    = str.bankSel;
  assign rfByteEn   = str.wrRf ? laneOh : '0;
  assign bankByteEn = str.wrBank ? laneOh : '0;
  assign rfWrData   = {LANES{toRf}};
  assign bankWrData = {LANES{rfByte}};
  assign bankEn     = str.useBank && !str.usePeer;
  assign peerEn     = str.useBank && str.usePeer;

  // R2: at most one register-file lane written per step
  a_r2_one_lane: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rfByteEn));
  // R6: fill devices never touch a bank
  a_r6_fill_no_bank: assert property (@(posedge clk) disable iff (!rstN)
    (str.active && str.fill) |-> (!bankEn && !peerEn && bankByteEn == '0));
  // R7: local and peer enables are exclusive
  a_r7_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(bankEn && peerEn));
endmodule

// File: rtl/scratch_xfer.sv
module scratch_xfer
  import spx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [7:0]  cmdDev,
  input  logic [4:0]  cmdReg,
  input  logic [1:0]  cmdLane,
  input  logic [6:0]  cmdLen,
  output logic        busy,
  output logic        err,
  output logic        macFwd,
  output logic [4:0]  rfAddr,
  output logic [3:0]  rfByteEn,
  output logic [31:0] rfWrData,
  input  logic [31:0] rfRdData,
  output logic [4:0]  bankAddr,
  output logic [1:0]  bankSel,
  output logic        bankEn,
  output logic        peerEn,
  output logic [3:0]  bankByteEn,
  output logic [31:0] bankWrData,
  input  logic [31:0] bankRdData
);
  strobe_t str;

  spx_ctrl #(.DEV_W(8), .MAX_LEN(124)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdDev(cmdDev), .cmdReg(cmdReg), .cmdLane(cmdLane), .cmdLen(cmdLen),
    .busy(busy), .err(err), .macFwd(macFwd), .str(str)
  );

  spx_dp u_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .rfAddr(rfAddr), .rfByteEn(rfByteEn), .rfWrData(rfWrData), .rfRdData(rfRdData),
    .bankAddr(bankAddr), .bankSel(bankSel), .bankEn(bankEn), .peerEn(peerEn),
    .bankByteEn(bankByteEn), .bankWrData(bankWrData), .bankRdData(bankRdData)
  );
endmodule

// File: tb/test_scratch_xfer.sv
`timescale 1ns/1ps
module test_scratch_xfer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [7:0] cmdDev = '0;
  logic [4:0] cmdReg = '0;
  logic [1:0] cmdLane = '0;
  logic [6:0] cmdLen = '0;
  logic busy, err, macFwd, bankEn, peerEn;
  logic [4:0] rfAddr, bankAddr;
  logic [3:0] rfByteEn, bankByteEn;
  logic [1:0] bankSel;
  logic [31:0] rfWrData, rfRdData, bankWrData, bankRdData;

  always #4 clk = ~clk;

  scratch_xfer i_scratch_xfer (.*);

  logic [31:0] rfMem [32];
  logic [31:0] bkMem [4][32];
  logic [31:0] rfRef [32];
  logic [31:0] bkRef [4][32];

  assign rfRdData   = rfMem[rfAddr];
  assign bankRdData = peerEn ? bkMem[3][bankAddr] : bkMem[bankSel][bankAddr];

  always @(posedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (rfByteEn[l]) rfMem[rfAddr][8*l +: 8] <= rfWrData[8*l +: 8];
      if (bankByteEn[l]) begin
        if (peerEn) bkMem[3][bankAddr][8*l +: 8] <= bankWrData[8*l +: 8];
        else if (bankEn) bkMem[bankSel][bankAddr][8*l +: 8] <= bankWrData[8*l +: 8];
      end
    end
  end

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] req;
    logic [4:0] addr;
    logic [1:0] lane;
    logic [3:0] rfBe;
    logic [7:0] rfByte;
    logic [3:0] bkBe;
    logic [7:0] bkByte;
    logic       bEn;
    logic       pEn;
    logic [1:0] sel;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int failures = 0;

  task automatic report(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per active cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (busy || err || macFwd) begin
        if (expQ.size() == 0) begin
          report(11, "unexpected activity", {29'd0, busy, err, macFwd}, 32'd0);
        end else begin
          item_t e;
          logic [1:0] k;
          e = expQ.pop_front();
          k = err ? 2'd1 : (macFwd ? 2'd2 : 2'd0);
          report(int'(e.req), "kind", {30'd0, k}, {30'd0, e.kind});
          if (e.kind == 2'd0) begin
            report(int'(e.req), "busy", {31'd0, busy}, 32'd1);
            report(int'(e.req), "rfAddr", {27'd0, rfAddr}, {27'd0, e.addr});
            report(int'(e.req), "bankAddr", {27'd0, bankAddr}, {27'd0, e.addr});
            report(int'(e.req), "rfByteEn", {28'd0, rfByteEn}, {28'd0, e.rfBe});
            report(int'(e.req), "bankByteEn", {28'd0, bankByteEn}, {28'd0, e.bkBe});
            report(int'(e.req), "bankEn/peerEn", {30'd0, bankEn, peerEn}, {30'd0, e.bEn, e.pEn});
            if (e.bEn) report(int'(e.req), "bankSel", {30'd0, bankSel}, {30'd0, e.sel});
            if (e.rfBe != 0) report(int'(e.req), "rf data", {24'd0, rfWrData[8*e.lane +: 8]}, {24'd0, e.rfByte});
            if (e.bkBe != 0) report(int'(e.req), "bank data", {24'd0, bankWrData[8*e.lane +: 8]}, {24'd0, e.bkByte});
          end else begin
            report(int'(e.req), "busy during pulse", {31'd0, busy}, 32'd0);
          end
        end
      end else if (rfByteEn != 0 || bankByteEn != 0) begin
        report(8, "write while idle", {24'd0, rfByteEn, bankByteEn}, 32'd0);
      end
    end
  end

  function automatic int devBank(input int dev);
    case (dev)
      10: return 0;
      11: return 1;
      12: return 2;
      14: return 3;
      default: return -1;
    endcase
  endfunction

  // predict and queue one transfer (valid commands only)
  task automatic predict(input int req, input int op, input int dev, input int r0, input int l0, input int len);
    int r = r0;
    int l = l0;
    int bi = devBank(dev);
    for (int n = 0; n < len; n++) begin
      item_t e;
      logic [7:0] rb, bb;
      e = '0;
      e.req = 8'(req);
      e.addr = 5'(r);
      e.lane = 2'(l);
      rb = rfRef[r][8*l +: 8];
      bb = (bi >= 0) ? bkRef[bi][r][8*l +: 8] : 8'h00;
      if (bi < 0) begin
        e.rfBe = 4'(1 << l);
        e.rfByte = (dev == 254) ? 8'hFF : 8'h00;
        rfRef[r][8*l +: 8] = e.rfByte;
      end else begin
        e.bEn = (bi < 3);
        e.pEn = (bi == 3);
        e.sel = 2'(bi);
        if (op == 0 || op == 2) begin
          e.rfBe = 4'(1 << l);
          e.rfByte = bb;
          rfRef[r][8*l +: 8] = bb;
        end
        if (op == 1 || op == 2) begin
          e.bkBe = 4'(1 << l);
          e.bkByte = rb;
          bkRef[bi][r][8*l +: 8] = rb;
        end
      end
      expQ.push_back(e);
      l++;
      if (l == 4) begin
        l = 0;
        r++;
      end
    end
  endtask

  task automatic pulse(input int req, input logic [1:0] kind);
    item_t e;
    e = '0;
    e.req = 8'(req);
    e.kind = kind;
    expQ.push_back(e);
  endtask

  task automatic drive(input int op, input int dev, input int r, input int l, input int len);
    cmdOp = 2'(op);
    cmdDev = 8'(dev);
    cmdReg = 5'(r);
    cmdLane = 2'(l);
    cmdLen = 7'(len);
    cmdValid = 1'b1;
    @(posedge clk);
    #1 cmdValid = 1'b0;
  endtask

  task automatic settle(input int req, input int cycles);
    repeat (cycles) @(posedge clk);
    #1;
    report(req, "missing output items", expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic xfer(input int req, input int op, input int dev, input int r, input int l, input int len);
    predict(req, op, dev, r, l, len);
    drive(op, dev, r, l, len);
    settle(req, len + 3);
  endtask

  task automatic reject(input int req, input int op, input int dev, input int r, input int l, input int len);
    pulse(req, 2'd1);
    drive(op, dev, r, l, len);
    settle(req, 4);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      rfMem[i] = 32'hA0000000 + i * 32'h01030507;
      rfRef[i] = rfMem[i];
      for (int k = 0; k < 4; k++) begin
        bkMem[k][i] = (32'h11000000 * (k + 1)) ^ (i * 32'h0F1E2D3C);
        bkRef[k][i] = bkMem[k][i];
      end
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    report(1, "reset busy/err/macFwd", {29'd0, busy, err, macFwd}, 32'd0);
    report(1, "reset enables", {22'd0, rfByteEn, bankByteEn, bankEn, peerEn}, 32'd0);
    @(posedge clk);
    #1;
    // R2 R4 R7 R12: read-in from local bank 0, crossing lanes
    xfer(2, 0, 10, 3, 1, 6);
    // R3 R7: write-out to local bank 1
    xfer(3, 1, 11, 10, 0, 9);
    // R5 R7: swap with local bank 2
    xfer(5, 2, 12, 20, 2, 5);
    // R5 R7: swap with peer bank
    xfer(7, 2, 14, 5, 3, 3);
    // R3: write-out to peer bank
    xfer(3, 1, 14, 8, 1, 4);
    // R6: fill with ones, then zeros ending exactly at byte 128 (R10 boundary)
    xfer(6, 0, 254, 0, 0, 7);
    xfer(6, 0, 255, 30, 1, 7);
    // R10: full-length transfer
    xfer(10, 0, 10, 0, 0, 124);
    // R8: unsupported combinations
    reject(8, 0, 7, 0, 0, 4);
    reject(8, 1, 254, 0, 0, 4);
    reject(8, 2, 255, 0, 0, 4);
    reject(8, 2, 0, 25, 0, 4);
    reject(8, 3, 10, 0, 0, 4);
    reject(8, 0, 13, 0, 0, 4);
    // R9: device 0 forwarding
    pulse(9, 2'd2);
    drive(0, 0, 25, 0, 4);
    settle(9, 4);
    pulse(9, 2'd2);
    drive(1, 0, 26, 0, 4);
    settle(9, 4);
    // R10: length and range limits
    reject(10, 0, 10, 0, 0, 0);
    reject(10, 0, 10, 0, 0, 125);
    reject(10, 1, 11, 31, 3, 2);
    // R11: a command during busy is ignored
    predict(11, 1, 12, 2, 0, 6);
    drive(1, 12, 2, 0, 6);
    @(posedge clk);
    #1;
    cmdOp = 2'd0; cmdDev = 8'd7; cmdReg = 5'd0; cmdLane = 2'd0; cmdLen = 7'd3;
    cmdValid = 1'b1;
    @(posedge clk);
    #1 cmdValid = 1'b0;
    settle(11, 9);
    // final memory comparison against reference copies
    for (int i = 0; i < 32; i++) begin
      report(2, "rf contents", rfMem[i], rfRef[i]);
      for (int k = 0; k < 4; k++) report(5, "bank contents", bkMem[k][i], bkRef[k][i]);
    end
    finishRun();
  end
endmodule